// File: doc/BRIEF.md
# Context-Configured Multiply-Accumulate Cell

This block is a single processing element meant to be tiled into a coarse-grained SIMD array. Its behaviour in each cycle is set by a 32-bit context word held in a local context register. The word chooses two 16-bit operands, an arithmetic or logic operation, a post-shift, and the register-file entry that receives the result. The array fabric places a word into the context register by pulsing `ctx_load`. The cell executes that word on every cycle in which `en` is high.

Operand A comes from a 16-way selector and operand B from an 8-way selector. The sources are the four nearest neighbours, a shared row/column bus, an array data bus, an express-lane input, the cell's own output, a sign-extended 12-bit immediate, and a four-entry local register file. The datapath is 28 bits wide. A 16x12 signed product can be added to the previous 28-bit result, so a multiply-accumulate completes in one cycle without losing precision. The 16-bit cell output is the low half of the stored 28-bit result.

Top module: `ctx_cell`

## Requirements
- R1: While `rst` is high at a clock edge, the context register, the 28-bit result, all four register-file entries and both drive flags clear. After reset `dout` is 0 and `bus_oe` and `lane_oe` are low.
- R2: Context word fields are placed as follows: bit 31 is bus drive, bit 30 is lane drive, bits 29:28 are the destination register, bit 27 is shift direction (1 = right), bits 26:23 are shift amount, bits 22:19 are A select, bits 18:16 are B select, bits 15:12 are opcode and bits 11:0 are the immediate. The A select codes are 0-3 for R0-R3, 4 north, 5 east, 6 south, 7 west, 8 data bus, 9 row/column bus, 10 express lane, 11 own `dout`, 12 immediate, and 13-15 zero.
- R3: Each executed operation writes the low 16 bits of its shifted result into the register-file entry named by bits 29:28. The other three entries do not change.
- R4: B select codes are 0-3 for R0-R3, 4 data bus, 5 north, 6 west and 7 south. Opcode 1 adds A and B and opcode 2 computes A minus B. Both treat the operands as signed 16-bit values.
- R5: Opcode 3 produces the absolute value of the signed difference A minus B. The result is never negative.
- R6: Opcode 4 produces the signed product of A and the 12-bit immediate.
- R7: Opcode 5 adds the signed product of A and the immediate to the previous 28-bit result before shifting. Up to 28 bits are kept, so the high bits can later be brought down by a right shift.
- R8: The 28-bit result is shifted left, or arithmetic-right, by 0 to 15 places. `dout` is its low 16 bits, truncated and not saturated.
- R9: Opcode 0 passes A through. When A select is 12, the 12-bit immediate is sign-extended to 16 bits.
- R10: Opcodes 6, 7 and 8 produce the bitwise AND, OR and XOR of A and B.
- R11: Opcodes 9 to 15 leave the result, the register file and the drive flags unchanged, even when `en` is high.
- R12: While `en` is low, the result, register file and drive flags hold. Loading a new context with `ctx_load` does not change the outputs.
- R13: Each executed operation sets `bus_oe` from context bit 31 and `lane_oe` from context bit 30.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Execute the held context this cycle |
| ctx_load | input | 1 | Capture `ctx_in` into the context register |
| ctx_in | input | 32 | Context word |
| nb_n | input | 16 | North neighbour output |
| nb_e | input | 16 | East neighbour output |
| nb_s | input | 16 | South neighbour output |
| nb_w | input | 16 | West neighbour output |
| dbus_in | input | 16 | Array data bus operand |
| rcbus_in | input | 16 | Row/column bus value |
| lane_in | input | 16 | Express-lane value |
| dout | output | 16 | Low 16 bits of the registered result |
| bus_oe | output | 1 | Cell requests to drive the row/column bus |
| lane_oe | output | 1 | Cell requests to drive the express lane |

## Verification
The arithmetic paths are tested with operand pairs that include negative values, such as -100 against 50 and a negative immediate. These separate signed handling from unsigned handling in add, subtract, absolute difference and multiply. The accumulate test keeps summing until the total passes 16 bits and then shifts it right by 12. Only a full 28-bit store gives the expected value. Shift tests use a negative value shifted right and a value whose top bit is shifted out on the left, which separate arithmetic from logical shifting and truncation from saturation. Unused opcodes and a low `en` are checked by reading the held output and then reading back the register-file entry that the ignored word named.

// File: rtl/ctx_cell_pkg.sv
package ctx_cell_pkg;
  localparam int CTX_W  = 32;
  localparam int IMM_W  = 12;
  localparam int NREG   = 4;
  localparam int RIDX_W = $clog2(NREG);
  localparam int SH_W   = 4;
  localparam int SELA_W = 4;
  localparam int SELB_W = 3;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_PASS = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_ABSD = 4'd3,
    OP_MUL  = 4'd4,
    OP_MAC  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8
  } op_e;

  typedef struct packed {
    logic              bus_wr;
    logic              lane_wr;
    logic [RIDX_W-1:0] dst;
    logic              shr;
    logic [SH_W-1:0]   sh;
    logic [SELA_W-1:0] sel_a;
    logic [SELB_W-1:0] sel_b;
    logic [OP_W-1:0]   op;
    logic [IMM_W-1:0]  imm;
  } ctx_t;
endpackage

// File: rtl/ctx_cell_regfile.sv
module ctx_cell_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 4,
  localparam int IW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [IW-1:0]      waddr,
  input  logic [DW-1:0]      wdata,
  output logic [NREG*DW-1:0] rd_all
);
  logic [DW-1:0] mem_q [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_rd
    assign rd_all[g*DW +: DW] = mem_q[g];
  end
endmodule

// File: rtl/ctx_cell_opsel.sv
module ctx_cell_opsel #(
  parameter int DW    = 16,
  parameter int NREG  = 4,
  parameter int IMM_W = 12
) (
  input  logic [NREG*DW-1:0] regs,
  input  logic [DW-1:0]      nb_n,
  input  logic [DW-1:0]      nb_e,
  input  logic [DW-1:0]      nb_s,
  input  logic [DW-1:0]      nb_w,
  input  logic [DW-1:0]      dbus,
  input  logic [DW-1:0]      rcbus,
  input  logic [DW-1:0]      lane,
  input  logic [DW-1:0]      fb,
  input  logic [IMM_W-1:0]   imm,
  input  logic [3:0]         sel_a,
  input  logic [2:0]         sel_b,
  output logic [DW-1:0]      opa,
  output logic [DW-1:0]      opb
);
  logic [DW-1:0] imm_x;
  logic [DW-1:0] src_a [16];
  logic [DW-1:0] src_b [8];

  assign imm_x = {{(DW-IMM_W){imm[IMM_W-1]}}, imm};

  for (genvar g = 0; g < NREG; g++) begin : g_rf_src
    assign src_a[g] = regs[g*DW +: DW];
    assign src_b[g] = regs[g*DW +: DW];
  end

  assign src_a[4]  = nb_n;
  assign src_a[5]  = nb_e;
  assign src_a[6]  = nb_s;
  assign src_a[7]  = nb_w;
  assign src_a[8]  = dbus;
  assign src_a[9]  = rcbus;
  assign src_a[10] = lane;
  assign src_a[11] = fb;
  assign src_a[12] = imm_x;
  assign src_a[13] = '0;
  assign src_a[14] = '0;
  assign src_a[15] = '0;

  assign src_b[4] = dbus;
  assign src_b[5] = nb_n;
  assign src_b[6] = nb_w;
  assign src_b[7] = nb_s;

  assign opa = src_a[sel_a];
  assign opb = src_b[sel_b];
endmodule

// File: rtl/ctx_cell_alu.sv
module ctx_cell_alu
  import ctx_cell_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 28,
  parameter int IMM_W = 12
) (
  input  logic [DW-1:0]    opa,
  input  logic [DW-1:0]    opb,
  input  logic [IMM_W-1:0] imm,
  input  logic [AW-1:0]    acc,
  input  logic [OP_W-1:0]  op,
  input  logic             shr,
  input  logic [SH_W-1:0]  sh,
  output logic             valid,
  output logic [AW-1:0]    res
);
  logic signed [AW-1:0] a_x, b_x, k_x, diff, prod, pre;

  assign a_x  = {{(AW-DW){opa[DW-1]}}, opa};
  assign b_x  = {{(AW-DW){opb[DW-1]}}, opb};
  assign k_x  = {{(AW-IMM_W){imm[IMM_W-1]}}, imm};
  assign diff = a_x - b_x;
  assign prod = a_x * k_x;

  always_comb begin
    valid = 1'b1;
    pre   = '0;
    case (op)
      OP_PASS: pre = a_x;
      OP_ADD:  pre = a_x + b_x;
      OP_SUB:  pre = diff;
      OP_ABSD: pre = diff[AW-1] ? -diff : diff;
      OP_MUL:  pre = prod;
      OP_MAC:  pre = prod + $signed(acc);
      OP_AND:  pre = {{(AW-DW){1'b0}}, opa & opb};
      OP_OR:   pre = {{(AW-DW){1'b0}}, opa | opb};
      OP_XOR:  pre = {{(AW-DW){1'b0}}, opa ^ opb};
      default: valid = 1'b0;
    endcase
  end

  assign res = shr ? AW'(pre >>> sh) : AW'(pre << sh);
endmodule

// File: rtl/ctx_cell.sv
module ctx_cell
  import ctx_cell_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             ctx_load,
  input  logic [CTX_W-1:0] ctx_in,
  input  logic [DW-1:0]    nb_n,
  input  logic [DW-1:0]    nb_e,
  input  logic [DW-1:0]    nb_s,
  input  logic [DW-1:0]    nb_w,
  input  logic [DW-1:0]    dbus_in,
  input  logic [DW-1:0]    rcbus_in,
  input  logic [DW-1:0]    lane_in,
  output logic [DW-1:0]    dout,
  output logic             bus_oe,
  output logic             lane_oe
);
  ctx_t               ctx_q;
  logic [AW-1:0]      acc_q;
  logic               bus_oe_q, lane_oe_q;
  logic [NREG*DW-1:0] regs;
  logic [DW-1:0]      opa, opb;
  logic [AW-1:0]      res;
  logic               op_ok, fire;

  always_ff @(posedge clk) begin
    if (rst) ctx_q <= '0;
    else if (ctx_load) ctx_q <= ctx_t'(ctx_in);
  end

  ctx_cell_opsel #(.DW(DW), .NREG(NREG), .IMM_W(IMM_W)) u_sel (
    .regs(regs), .nb_n(nb_n), .nb_e(nb_e), .nb_s(nb_s), .nb_w(nb_w),
    .dbus(dbus_in), .rcbus(rcbus_in), .lane(lane_in), .fb(dout),
    .imm(ctx_q.imm), .sel_a(ctx_q.sel_a), .sel_b(ctx_q.sel_b),
    .opa(opa), .opb(opb)
  );

  ctx_cell_alu #(.DW(DW), .AW(AW), .IMM_W(IMM_W)) u_alu (
    .opa(opa), .opb(opb), .imm(ctx_q.imm), .acc(acc_q), .op(ctx_q.op),
    .shr(ctx_q.shr), .sh(ctx_q.sh), .valid(op_ok), .res(res)
  );

  assign fire = en && op_ok;

  ctx_cell_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst), .we(fire), .waddr(ctx_q.dst),
    .wdata(res[DW-1:0]), .rd_all(regs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      bus_oe_q  <= 1'b0;
      lane_oe_q <= 1'b0;
    end else if (fire) begin
      acc_q     <= res;
      bus_oe_q  <= ctx_q.bus_wr;
      lane_oe_q <= ctx_q.lane_wr;
    end
  end

  assign dout    = acc_q[DW-1:0];
  assign bus_oe  = bus_oe_q;
  assign lane_oe = lane_oe_q;
endmodule

// File: rtl/ctx_cell_chk.sv
module ctx_cell_chk #(
  parameter int DW = 16,
  parameter int AW = 28
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic [31:0]   ctx_w,
  input logic [AW-1:0] acc,
  input logic [DW-1:0] dout,
  input logic          bus_oe,
  input logic          lane_oe
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (dout == '0 && !bus_oe && !lane_oe));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(acc) && $stable(bus_oe) && $stable(lane_oe)));

  // R11
  spare_op_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && ctx_w[15:12] > 4'd8) |=> $stable(acc));

  // R13
  bus_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (en && ctx_w[15:12] <= 4'd8) |=> (bus_oe == $past(ctx_w[31]) && lane_oe == $past(ctx_w[30])));

  // R5
  absdiff_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (en && ctx_w[15:12] == 4'd3 && ctx_w[26:23] == 4'd0) |=> !acc[AW-1]);
endmodule

bind ctx_cell ctx_cell_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .en(en), .ctx_w(ctx_q), .acc(acc_q),
  .dout(dout), .bus_oe(bus_oe), .lane_oe(lane_oe)
);

// File: tb/ctx_cell_tb.sv
module ctx_cell_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0, ctx_load = 1'b0;
  logic [31:0] ctx_in = '0;
  logic [15:0] nb_n = '0, nb_e = '0, nb_s = '0, nb_w = '0;
  logic [15:0] dbus_in = '0, rcbus_in = '0, lane_in = '0;
  logic [15:0] dout;
  logic        bus_oe, lane_oe;
  int          n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  ctx_cell dut_i (
    .clk(clk), .rst(rst), .en(en), .ctx_load(ctx_load), .ctx_in(ctx_in),
    .nb_n(nb_n), .nb_e(nb_e), .nb_s(nb_s), .nb_w(nb_w),
    .dbus_in(dbus_in), .rcbus_in(rcbus_in), .lane_in(lane_in),
    .dout(dout), .bus_oe(bus_oe), .lane_oe(lane_oe)
  );

  function automatic logic [31:0] mk(input logic bw, input logic lw, input logic [1:0] dst,
                                     input logic shr, input logic [3:0] sh, input logic [3:0] sa,
                                     input logic [2:0] sb, input logic [3:0] op, input logic [11:0] imm);
    return {bw, lw, dst, shr, sh, sa, sb, op, imm};
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run(input logic [31:0] w);
    @(negedge clk); ctx_in = w; ctx_load = 1'b1; en = 1'b0;
    @(negedge clk); ctx_load = 1'b0; en = 1'b1;
    @(negedge clk); en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 dout", dout, 16'h0000);
    chk("R1 flags", {14'd0, bus_oe, lane_oe}, 16'h0000);
  endtask

  task automatic t_pass;
    nb_n = 16'h1A2B; run(mk(0,0,0,0,0,4,0,0,0));
    chk("R2 north pass", dout, 16'h1A2B);
    rcbus_in = 16'h0BAD; run(mk(0,0,0,0,0,9,0,0,0));
    chk("R2 rowcol pass", dout, 16'h0BAD);
  endtask

  task automatic t_regfile;
    dbus_in = 16'h00C3; run(mk(0,0,2,0,0,8,0,0,0));
    dbus_in = 16'h0000; run(mk(0,0,0,0,0,2,0,0,0));
    chk("R3 R2 readback", dout, 16'h00C3);
    run(mk(0,0,0,0,0,1,0,0,0));
    chk("R3 R1 untouched", dout, 16'h0000);
  endtask

  task automatic t_addsub;
    nb_n = 16'd100; nb_w = 16'hFFE2; run(mk(0,0,0,0,0,4,6,1,0));
    chk("R4 add", dout, 16'd70);
    nb_n = 16'd5; nb_s = 16'd9; run(mk(0,0,0,0,0,4,7,2,0));
    chk("R4 sub", dout, 16'hFFFC);
  endtask

  task automatic t_absd;
    nb_n = 16'd5; nb_s = 16'd9; run(mk(0,0,0,0,0,4,7,3,0));
    chk("R5 absdiff small", dout, 16'd4);
    nb_n = 16'hFF9C; nb_s = 16'd50; run(mk(0,0,0,0,0,4,7,3,0));
    chk("R5 absdiff signed", dout, 16'd150);
  endtask

  task automatic t_mul;
    nb_n = 16'd300; run(mk(0,0,0,0,0,4,0,4,12'hFF9));
    chk("R6 mul", dout, 16'hF7CC);
  endtask

  task automatic t_mac;
    run(mk(0,0,0,0,0,13,0,0,0));
    nb_n = 16'd1000;
    for (int i = 0; i < 3; i++) run(mk(0,0,0,0,0,4,0,5,12'd2000));
    chk("R7 mac low", dout, 16'h8D80);
    run(mk(0,0,0,1,12,13,0,5,0));
    chk("R7 mac high", dout, 16'h05B8);
  endtask

  task automatic t_shift;
    nb_n = 16'h0123; run(mk(0,0,0,0,4,4,0,0,0));
    chk("R8 left", dout, 16'h1230);
    nb_n = 16'hFF00; run(mk(0,0,0,1,4,4,0,0,0));
    chk("R8 arith right", dout, 16'hFFF0);
    nb_n = 16'h8001; run(mk(0,0,0,0,1,4,0,0,0));
    chk("R8 truncate", dout, 16'h0002);
  endtask

  task automatic t_const;
    run(mk(0,0,0,0,0,12,0,0,12'hFFB));
    chk("R9 neg imm", dout, 16'hFFFB);
    run(mk(0,0,0,0,0,12,0,0,12'h7FF));
    chk("R9 pos imm", dout, 16'h07FF);
  endtask

  task automatic t_logic;
    nb_n = 16'hF0F0; nb_w = 16'h0FF0;
    run(mk(0,0,0,0,0,4,6,6,0)); chk("R10 and", dout, 16'h00F0);
    run(mk(0,0,0,0,0,4,6,7,0)); chk("R10 or", dout, 16'hFFF0);
    run(mk(0,0,0,0,0,4,6,8,0)); chk("R10 xor", dout, 16'hFF00);
  endtask

  task automatic t_noop;
    nb_n = 16'h1234; run(mk(0,0,3,0,0,4,0,0,0));
    nb_n = 16'h5555; run(mk(1,1,3,0,0,4,0,9,0));
    chk("R11 op9 holds", dout, 16'h1234);
    chk("R11 flags hold", {14'd0, bus_oe, lane_oe}, 16'h0000);
    run(mk(0,0,3,0,0,4,0,15,0));
    run(mk(0,0,0,0,0,3,0,0,0));
    chk("R11 R3 untouched", dout, 16'h1234);
  endtask

  task automatic t_enable;
    nb_n = 16'h7777;
    @(negedge clk); ctx_in = mk(1,0,1,0,0,4,0,0,0); ctx_load = 1'b1;
    @(negedge clk); ctx_load = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 dout holds", dout, 16'h1234);
    chk("R12 flag holds", {15'd0, bus_oe}, 16'h0000);
    run(mk(0,0,0,0,0,1,0,0,0));
    chk("R12 R1 untouched", dout, 16'h0000);
  endtask

  task automatic t_flags;
    run(mk(1,0,0,0,0,13,0,0,0));
    chk("R13 bus only", {14'd0, bus_oe, lane_oe}, 16'h0002);
    run(mk(0,1,0,0,0,13,0,0,0));
    chk("R13 lane only", {14'd0, bus_oe, lane_oe}, 16'h0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset(); t_pass(); t_regfile(); t_addsub(); t_absd(); t_mul();
    t_mac(); t_shift(); t_const(); t_logic(); t_noop(); t_enable(); t_flags();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule